// File: doc/BRIEF.md
# Next-Page Receive Status Tracker

This block keeps two status flags for an auto-negotiation engine: one says a link-partner page has arrived, the other says whether the most recent arrival was the base page. The negotiation logic pulses `page_rx_i` for each page it accepts and marks base pages with `page_is_base_i`. It pulses `neg_start_i` when a fresh negotiation begins. Software sees both flags through a status-register read, and that read clears them.

In normal mode the page flag stays set until a read clears it, and a new negotiation leaves it alone. With `alt_mode_i` high, a new negotiation also wipes both flags. Software then cannot mistake a stale flag for a page from the current negotiation. When software sees the base-page flag set, it knows a negotiation has restarted and its next pages must be sent again.

The read strobe lasts one cycle. During that cycle the returned bits show the flag values from before the clear. If a page arrives in the same cycle as a clear, the arrival wins, so no page is lost.

Top module: `np_status_tracker`

## Requirements
- R1: A synchronous active-high reset clears both flags to 0. A read strobe after reset returns 2'b00.
- R2: A `page_rx_i` pulse sets the page flag (read bit 0) from the next cycle on. The flag stays set through any number of idle cycles until a read clears it.
- R3: While `rd_stb_i` is high, `rd_data_o` bit 0 is the page flag, bit 1 is the base-page flag, and any higher bits are 0. Both flags are shown as they were before that read's clear. While `rd_stb_i` is low, `rd_data_o` is all zeros.
- R4: A read strobe with no page arriving in the same cycle clears both flags in the next cycle.
- R5: When `page_rx_i` and `rd_stb_i` are high in the same cycle, the read returns the old flags and the page arrival takes effect afterwards: the page flag is 1 and the base-page flag follows `page_is_base_i`.
- R6: On each `page_rx_i` pulse the base-page flag takes the value of `page_is_base_i`: 1 for a base page, 0 for any other page.
- R7: With `alt_mode_i` = 1, a `neg_start_i` pulse with no page arriving in the same cycle clears both flags in the next cycle.
- R8: With `alt_mode_i` = 0, `neg_start_i` changes neither flag.
- R9: With `alt_mode_i` = 1, when `page_rx_i` and `neg_start_i` are high in the same cycle, the page flag ends up set and the base-page flag follows `page_is_base_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| page_rx_i | input | 1 | One-cycle pulse for each received page |
| page_is_base_i | input | 1 | High when the page arriving with `page_rx_i` is the base page |
| neg_start_i | input | 1 | One-cycle pulse when a new negotiation starts |
| alt_mode_i | input | 1 | 1 selects alternate next-page behaviour (auto-clear on new negotiation) |
| rd_stb_i | input | 1 | One-cycle status-register read strobe |
| rd_data_o | output | RD_W | Status bits returned for a read: bit 0 page flag, bit 1 base-page flag |

## Verification
Directed sequences come first. They check that the page flag is sticky across idle cycles, that a read returns the old flags and then clears them, and that a base page followed by a non-base page moves the base-page flag up and back down. Next, `neg_start_i` is pulsed once with `alt_mode_i` low and once with it high. This tells the optional auto-clear apart from the plain sticky behaviour. A page arrival is then placed in the same cycle as a read, and again in the same cycle as a new negotiation, to confirm that the set wins in both cases. A long pseudo-random stream of all five inputs follows, compared every cycle against a behavioural model. It covers the overlaps the directed cases miss.

// File: rtl/np_status_pkg.sv
package np_status_pkg;

    localparam int unsigned FLAG_CNT = 2;
    localparam int unsigned PAGE_IDX = 0;
    localparam int unsigned BASE_IDX = 1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_ALT    = 1'b1
    } np_mode_e;

    // bit 1 = base-page flag, bit 0 = page-received flag
    typedef struct packed {
        logic base;
        logic page;
    } np_flags_t;

    typedef struct packed {
        logic load;
        logic load_val;
        logic clear;
    } flag_ctrl_t;

    // a load has priority over a clear so no arrival is lost
    function automatic logic flag_next(input flag_ctrl_t c, input logic q);
        logic n;
        if (c.load)
            n = c.load_val;
        else if (c.clear)
            n = 1'b0;
        else
            n = q;
        return n;
    endfunction

endpackage

// File: rtl/np_evt_decode.sv
module np_evt_decode
    import np_status_pkg::*;
(
    input  logic                        page_rx_i,
    input  logic                        page_is_base_i,
    input  logic                        neg_start_i,
    input  logic                        alt_mode_i,
    input  logic                        rd_stb_i,
    output flag_ctrl_t [FLAG_CNT-1:0]   ctrl_o
);

    np_mode_e mode;
    logic     wipe;
    logic     clr_any;

    always_comb begin
        mode    = np_mode_e'(alt_mode_i);
        wipe    = (mode == MODE_ALT) && neg_start_i;
        clr_any = rd_stb_i || wipe;

        ctrl_o[PAGE_IDX].load     = page_rx_i;
        ctrl_o[PAGE_IDX].load_val = 1'b1;
        ctrl_o[PAGE_IDX].clear    = clr_any;

        ctrl_o[BASE_IDX].load     = page_rx_i;
        ctrl_o[BASE_IDX].load_val = page_is_base_i;
        ctrl_o[BASE_IDX].clear    = clr_any;
    end

endmodule

// File: rtl/np_flag_cell.sv
module np_flag_cell
    import np_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flag_ctrl_t ctrl_i,
    output logic       q_o
);

    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else
            q_o <= flag_next(ctrl_i, q_o);
    end

endmodule

// File: rtl/np_rd_port.sv
module np_rd_port
    import np_status_pkg::*;
#(
    parameter int unsigned RD_W = 2
) (
    input  logic            rd_stb_i,
    input  np_flags_t       flags_i,
    output logic [RD_W-1:0] rd_data_o
);

    localparam int unsigned FW = $bits(np_flags_t);

    always_comb begin
        rd_data_o = '0;
        if (rd_stb_i)
            rd_data_o[FW-1:0] = flags_i;
    end

endmodule

// File: rtl/np_status_tracker.sv
module np_status_tracker
    import np_status_pkg::*;
#(
    parameter int unsigned RD_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            page_rx_i,
    input  logic            page_is_base_i,
    input  logic            neg_start_i,
    input  logic            alt_mode_i,
    input  logic            rd_stb_i,
    output logic [RD_W-1:0] rd_data_o
);

    flag_ctrl_t [FLAG_CNT-1:0] ctrl;
    logic       [FLAG_CNT-1:0] flag_q;
    np_flags_t                 flags;

    np_evt_decode u_dec (
        .page_rx_i      (page_rx_i),
        .page_is_base_i (page_is_base_i),
        .neg_start_i    (neg_start_i),
        .alt_mode_i     (alt_mode_i),
        .rd_stb_i       (rd_stb_i),
        .ctrl_o         (ctrl)
    );

    for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
        np_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctrl_i (ctrl[i]),
            .q_o    (flag_q[i])
        );
    end

    assign flags = np_flags_t'(flag_q);

    np_rd_port #(.RD_W(RD_W)) u_rd (
        .rd_stb_i  (rd_stb_i),
        .flags_i   (flags),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/np_status_chk.sv
module np_status_chk
    import np_status_pkg::*;
#(
    parameter int unsigned RD_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            page_rx_i,
    input logic            page_is_base_i,
    input logic            neg_start_i,
    input logic            alt_mode_i,
    input logic            rd_stb_i,
    input logic [RD_W-1:0] rd_data_o,
    input np_flags_t       flags
);

    // R2
    page_set_chk: assert property (@(posedge clk) disable iff (rst)
        page_rx_i |=> flags.page);

    // R6
    base_load_chk: assert property (@(posedge clk) disable iff (rst)
        page_rx_i |=> flags.base == $past(page_is_base_i));

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && !page_rx_i) |=> (!flags.page && !flags.base));

    // R7
    alt_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (alt_mode_i && neg_start_i && !page_rx_i) |=> (!flags.page && !flags.base));

    // R8
    norm_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!alt_mode_i && !page_rx_i && !rd_stb_i) |=> $stable(flags));

    // R3
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |-> rd_data_o == '0);

    // R3
    rd_show_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb_i |-> (rd_data_o[0] == flags.page && rd_data_o[1] == flags.base));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!flags.page && !flags.base));

endmodule

bind np_status_tracker np_status_chk #(.RD_W(RD_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .page_rx_i      (page_rx_i),
    .page_is_base_i (page_is_base_i),
    .neg_start_i    (neg_start_i),
    .alt_mode_i     (alt_mode_i),
    .rd_stb_i       (rd_stb_i),
    .rd_data_o      (rd_data_o),
    .flags          (flags)
);

// File: tb/sim_np_status_tracker.sv
module sim_np_status_tracker;

    localparam int RD_W = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            page_rx = 1'b0;
    logic            is_base = 1'b0;
    logic            neg = 1'b0;
    logic            alt = 1'b0;
    logic            rd = 1'b0;
    logic [RD_W-1:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference state
    bit m_page = 0;
    bit m_base = 0;

    always #10 clk = ~clk;

    np_status_tracker #(.RD_W(RD_W)) u0 (
        .clk            (clk),
        .rst            (rst),
        .page_rx_i      (page_rx),
        .page_is_base_i (is_base),
        .neg_start_i    (neg),
        .alt_mode_i     (alt),
        .rd_stb_i       (rd),
        .rd_data_o      (rd_data)
    );

    // one clock: drive, compare the output before the edge, advance the model
    task automatic step(input bit p, input bit b, input bit n, input bit a,
                        input bit r, input string tag);
        logic [RD_W-1:0] exp;
        @(negedge clk);
        page_rx = p; is_base = b; neg = n; alt = a; rd = r;
        #1;
        exp = '0;
        if (r) begin
            exp[0] = m_page;
            exp[1] = m_base;
        end
        n_chk++;
        if (rd_data !== exp) begin
            n_err++;
            $display("FAIL %s: rd_data actual=%b expected=%b", tag, rd_data, exp);
        end
        @(posedge clk);
        if (p) begin
            m_page = 1;
            m_base = b;
        end else if (r || (a && n)) begin
            m_page = 0;
            m_base = 0;
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        step(0, 0, 0, 0, 1, "R1");

        // R2 sticky page flag, R3 read shows pre-clear value, R4 cleared after
        step(1, 0, 0, 0, 0, "R2");
        repeat (4) idle("R2");
        step(0, 0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, 1, "R4");

        // R6 base page then non-base page
        step(1, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 1, "R6");
        step(1, 1, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 1, "R6");

        // R8 normal mode: new negotiation leaves flags
        step(1, 1, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 1, "R8");

        // R7 alternate mode: new negotiation wipes both flags
        step(1, 1, 0, 1, 0, "R7");
        step(0, 0, 1, 1, 0, "R7");
        step(0, 0, 0, 1, 1, "R7");

        // R5 set wins over same-cycle read
        step(1, 0, 0, 0, 0, "R5");
        step(1, 1, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, "R5");

        // R9 set wins over same-cycle new negotiation in alternate mode
        step(1, 1, 1, 1, 0, "R9");
        step(0, 0, 0, 1, 1, "R9");

        // mixed random stream, every cycle against the model (R3 read path)
        for (int i = 0; i < 2000; i++) begin
            step(bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 5) == 0), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 2) == 0), "R3");
        end
        idle("R3");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule